// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block is a small translation cache that sits between an address-generating unit and the physical memory path. A 31-bit virtual address is presented on the lookup port. Its upper 19 bits, the virtual page number, are compared against every stored entry in the same cycle. When a valid entry matches, the block returns a 27-bit physical address. That address is the entry's 15-bit physical page number placed above the unchanged 12-bit offset of a 4 KB page. When nothing matches, the block only reports the miss. Walking the page table and refilling the buffer are left to whatever agent drives the write port.

Each entry holds a valid flag, a virtual page number and a physical page number. The number of entries is a parameter, with a default of 2 and a supported range of 1 to 16. The write port installs one entry per cycle at a chosen index and marks it valid. A flush input invalidates the whole buffer in a single cycle.

Software is expected never to hold two valid entries for the same page. If that does happen, the lowest-index matching entry supplies the result, so the output stays deterministic. The reset input is asynchronous and active low, and its deassertion is expected to arrive synchronised to the clock.

Top module: `xlate_buf`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss until an entry has been written.
- R2: A write with `wr_en` high installs the given virtual and physical page numbers at index `wr_idx` and marks that entry valid. The new entry takes part in lookups from the cycle after the write edge, not in the write cycle itself.
- R3: A lookup hits when some valid entry's virtual page number equals `lookup_va[30:12]`. In that same cycle, with no register on the path, `lookup_pa[26:15]`... more precisely `lookup_pa[26:12]` carries that entry's physical page number (for example, page 0x00002 mapped to page 0x7FFF turns address 0x247C into 0x7FFF47C).
- R4: On a hit, `lookup_pa[11:0]` equals `lookup_va[11:0]` for every offset value.
- R5: On a miss, `lookup_hit` is 0, and both `lookup_pa` and `lookup_way` are 0.
- R6: A cycle with `flush` high and `wr_en` low leaves every entry invalid from the next cycle.
- R7: When `flush` and `wr_en` are high in the same cycle, the written entry is valid afterwards and all other entries are invalid.
- R8: Writing an index that already holds a valid entry replaces its mapping. The old virtual page then misses unless another entry holds it.
- R9: When several valid entries match, the one with the lowest index supplies the physical page number. `lookup_way` always reports the index of the entry that supplied the hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| flush | input | 1 | Invalidate all entries at the next edge |
| wr_en | input | 1 | Install an entry at the next edge |
| wr_idx | input | IDX_W (1 by default) | Index of the entry to install |
| wr_vpn | input | 19 | Virtual page number to install |
| wr_ppn | input | 15 | Physical page number to install |
| lookup_va | input | 31 | Virtual address to translate |
| lookup_hit | output | 1 | A valid entry matches the lookup page |
| lookup_pa | output | 27 | Translated physical address, zero on a miss |
| lookup_way | output | IDX_W (1 by default) | Index of the supplying entry, zero on a miss |

## Verification
A wrong valid flag or a corrupted page number in any entry appears at the ports in the very cycle its virtual page is next presented. It shows as a wrong hit flag, a wrong page field or a wrong way index. A broken priority chain shows only when duplicate pages are stored, so the bench installs duplicates on purpose and then removes the lower one, which exposes the higher entry. Ordering faults between flush and write show one cycle after the edge where both are asserted. The bench therefore probes pages on every cycle with a behavioural model of the entry table.

// File: rtl/xlate_buf_pkg.sv
package xlate_buf_pkg;
  // Default address geometry: 4 KB pages, 31-bit virtual, 27-bit physical.
  localparam int unsigned XB_VA_W   = 31;
  localparam int unsigned XB_PA_W   = 27;
  localparam int unsigned XB_OFF_W  = 12;
  localparam int unsigned XB_MAX_ENTRIES = 16;

  // Width of an index able to address n entries (at least one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xlate_slot.sv
// One buffer entry: valid flag, page-number pair and its own comparator.
module xlate_slot #(
  parameter int unsigned VPN_W = 19,
  parameter int unsigned PPN_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_sel,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [VPN_W-1:0] probe_vpn,
  output logic             match,
  output logic [PPN_W-1:0] ppn_q
);
  logic             valid_q, valid_d;
  logic [VPN_W-1:0] vpn_q, vpn_d;
  logic [PPN_W-1:0] ppn_d;
  logic             pair_en;

  // Next state: an install overrides a flush in the same cycle.
  always_comb begin
    pair_en = wr_sel;
    valid_d = valid_q;
    if (flush)  valid_d = 1'b0;
    if (wr_sel) valid_d = 1'b1;
    vpn_d = wr_vpn;
    ppn_d = wr_ppn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // Page numbers carry no reset; they are qualified by valid_q.
  always_ff @(posedge clk) begin
    if (pair_en) begin
      vpn_q <= vpn_d;
      ppn_q <= ppn_d;
    end
  end

  assign match = valid_q && (vpn_q == probe_vpn);
endmodule

// File: rtl/xlate_first_hit.sv
// Lowest-index priority pick among matching entries, one-hot steered mux.
module xlate_first_hit #(
  parameter int unsigned N     = 2,
  parameter int unsigned W     = 15,
  parameter int unsigned IDX_W = 1
) (
  input  logic [N-1:0]   match,
  input  logic [N*W-1:0] ppn_flat,
  output logic [N-1:0]   first_vec,
  output logic           any,
  output logic [IDX_W-1:0] idx,
  output logic [W-1:0]   ppn
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign first_vec[g] = match[g] && !seen[g];
    assign seen[g+1]    = seen[g] || match[g];
  end

  assign any = seen[N];

  always_comb begin
    ppn = '0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      ppn = ppn | ({W{first_vec[i]}} & ppn_flat[i*W +: W]);
      if (first_vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xlate_buf_pkg::*;
#(
  parameter int unsigned ENTRIES = 2,
  parameter int unsigned VA_W    = XB_VA_W,
  parameter int unsigned PA_W    = XB_PA_W,
  parameter int unsigned OFF_W   = XB_OFF_W,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PPN_W  = PA_W - OFF_W,
  localparam int unsigned IDX_W  = idx_width(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [VA_W-1:0]  lookup_va,
  output logic             lookup_hit,
  output logic [PA_W-1:0]  lookup_pa,
  output logic [IDX_W-1:0] lookup_way
);
  logic [ENTRIES-1:0]       wr_sel;
  logic [ENTRIES-1:0]       match;
  logic [ENTRIES-1:0]       first_vec;
  logic [ENTRIES*PPN_W-1:0] ppn_flat;
  logic [VPN_W-1:0]         probe_vpn;
  logic [OFF_W-1:0]         probe_off;
  logic [PPN_W-1:0]         sel_ppn;
  logic                     any_hit;
  logic [IDX_W-1:0]         sel_idx;

  assign probe_vpn = lookup_va[VA_W-1:OFF_W];
  assign probe_off = lookup_va[OFF_W-1:0];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign wr_sel[g] = wr_en && (wr_idx == IDX_W'(g));

    xlate_slot #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .wr_sel    (wr_sel[g]),
      .wr_vpn    (wr_vpn),
      .wr_ppn    (wr_ppn),
      .probe_vpn (probe_vpn),
      .match     (match[g]),
      .ppn_q     (ppn_flat[g*PPN_W +: PPN_W])
    );
  end

  xlate_first_hit #(.N(ENTRIES), .W(PPN_W), .IDX_W(IDX_W)) u_pick (
    .match     (match),
    .ppn_flat  (ppn_flat),
    .first_vec (first_vec),
    .any       (any_hit),
    .idx       (sel_idx),
    .ppn       (sel_ppn)
  );

  always_comb begin
    lookup_hit = any_hit;
    lookup_way = sel_idx;
    lookup_pa  = '0;
    if (any_hit) lookup_pa = {sel_ppn, probe_off};
  end
endmodule

// File: rtl/xlate_buf_chk.sv
module xlate_buf_chk #(
  parameter int unsigned ENTRIES = 2,
  parameter int unsigned VA_W    = 31,
  parameter int unsigned PA_W    = 27,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned IDX_W   = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   wr_en,
  input logic [VA_W-OFF_W-1:0]  wr_vpn,
  input logic [VA_W-1:0]        lookup_va,
  input logic                   lookup_hit,
  input logic [PA_W-1:0]        lookup_pa,
  input logic [IDX_W-1:0]       lookup_way,
  input logic [ENTRIES-1:0]     first_vec
);
  logic seen_edge_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_edge_q <= 1'b0;
    else        seen_edge_q <= 1'b1;
  end

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_edge_q |-> !lookup_hit);

  assert_install_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((lookup_va[VA_W-1:OFF_W] != $past(wr_vpn)) || lookup_hit));

  assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |-> (lookup_pa[OFF_W-1:0] == lookup_va[OFF_W-1:0]));

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_hit |-> (lookup_pa == '0 && lookup_way == '0));

  assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wr_en) |=> !lookup_hit);

  assert_single_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_vec));

  assert_way_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |-> first_vec[lookup_way]);
endmodule

bind xlate_buf xlate_buf_chk #(
  .ENTRIES (ENTRIES),
  .VA_W    (VA_W),
  .PA_W    (PA_W),
  .OFF_W   (OFF_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .wr_en      (wr_en),
  .wr_vpn     (wr_vpn),
  .lookup_va  (lookup_va),
  .lookup_hit (lookup_hit),
  .lookup_pa  (lookup_pa),
  .lookup_way (lookup_way),
  .first_vec  (first_vec)
);

// File: tb/xlate_buf_tb.sv
`timescale 1ns/1ps
module xlate_buf_tb;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        wr_en;
  logic [1:0]  wr_idx;
  logic [18:0] wr_vpn;
  logic [14:0] wr_ppn;
  logic [30:0] lookup_va;
  logic        lookup_hit;
  logic [26:0] lookup_pa;
  logic [1:0]  lookup_way;

  always #2.5 clk = ~clk;

  xlate_buf #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .lookup_va(lookup_va),
    .lookup_hit(lookup_hit), .lookup_pa(lookup_pa), .lookup_way(lookup_way)
  );

  // Behavioural model of the entry table.
  bit          m_v   [N];
  bit   [18:0] m_vpn [N];
  bit   [14:0] m_ppn [N];

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  bit [31:0] rng = 32'h1234_5678;

  task automatic step(input string req, input logic [30:0] va,
                      input logic we, input logic [1:0] idx,
                      input logic [18:0] vpn, input logic [14:0] ppn,
                      input logic fl);
    bit          e_hit;
    bit   [26:0] e_pa;
    bit   [1:0]  e_way;
    @(negedge clk);
    lookup_va = va; wr_en = we; wr_idx = idx; wr_vpn = vpn; wr_ppn = ppn; flush = fl;
    #1;
    e_hit = 1'b0; e_pa = '0; e_way = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_v[i] && m_vpn[i] == va[30:12]) begin
        e_hit = 1'b1; e_way = 2'(i); e_pa = {m_ppn[i], va[11:0]};
      end
    end
    checks++;
    if (lookup_hit !== e_hit || lookup_pa !== e_pa || lookup_way !== e_way) begin
      fails++;
      $display("FAIL %s: va=%h hit=%0b pa=%h way=%0d expected hit=%0b pa=%h way=%0d",
               req, va, lookup_hit, lookup_pa, lookup_way, e_hit, e_pa, e_way);
    end
    @(posedge clk);
    if (fl) for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    if (we) begin
      m_v[idx] = 1'b1; m_vpn[idx] = vpn; m_ppn[idx] = ppn;
    end
  endtask

  task automatic look(input string req, input logic [30:0] va);
    step(req, va, 1'b0, 2'd0, 19'd0, 15'd0, 1'b0);
  endtask

  function automatic logic [18:0] pool(input logic [2:0] k);
    case (k)
      3'd0: return 19'h00002;
      3'd1: return 19'h00005;
      3'd2: return 19'h7FFFD;
      3'd3: return 19'h00009;
      default: return 19'h40000;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; flush = 1'b0; wr_en = 1'b0; wr_idx = '0;
    wr_vpn = '0; wr_ppn = '0; lookup_va = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    look("R1", 31'h0000_247C);
    look("R1", 31'h0000_0000);

    // R2: install is not visible in its own cycle, visible afterwards
    step("R2", 31'h0000_247C, 1'b1, 2'd0, 19'h00002, 15'h7FFF, 1'b0);
    look("R3", 31'h0000_247C);
    step("R2", 31'h7FFF_D000, 1'b1, 2'd1, 19'h7FFFD, 15'h0000, 1'b0);

    // R4: offsets pass unchanged
    look("R4", 31'h7FFF_D000);
    look("R4", 31'h7FFF_DFFF);
    look("R4", 31'h0000_2555);
    look("R4", 31'h0000_2AAA);

    // R5: miss drives zeros
    look("R5", 31'h0000_5F20);
    look("R5", 31'h7FFF_FFFF);

    // R8: overwrite an index
    step("R8", 31'h0000_5F20, 1'b1, 2'd0, 19'h00005, 15'h0001, 1'b0);
    look("R8", 31'h0000_247C);
    look("R8", 31'h0000_5F20);

    // R9: duplicate pages, lowest index wins; then expose the higher one
    step("R9", 31'h0000_5F20, 1'b1, 2'd3, 19'h00005, 15'h2222, 1'b0);
    look("R9", 31'h0000_5F20);
    step("R9", 31'h0000_5F20, 1'b1, 2'd0, 19'h00006, 15'h1111, 1'b0);
    look("R9", 31'h0000_5F20);
    look("R9", 31'h0000_6123);

    // R6: flush alone empties the buffer
    step("R6", 31'h0000_5F20, 1'b0, 2'd0, 19'h0, 15'h0, 1'b1);
    look("R6", 31'h0000_5F20);
    look("R6", 31'h7FFF_D001);

    // R7: flush and write together keep only the written entry
    step("R7", 31'h0000_0000, 1'b1, 2'd1, 19'h00009, 15'h3333, 1'b0);
    step("R7", 31'h0000_9000, 1'b1, 2'd2, 19'h00002, 15'h4444, 1'b1);
    look("R7", 31'h0000_9000);
    look("R7", 31'h0000_2010);

    // R3: mixed traffic from a small page pool
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      rng = rng * 32'd1103515245 + 32'd12345;
      r = rng;
      step("R3", {pool(r[15:13]), r[27:16]}, (r[3:0] < 4'd5), r[9:8],
           pool(r[12:10]), r[30:16], (r[7:4] == 4'd0) && (r[31]));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule